// File: doc/BRIEF.md
# Code-Address Breakpoint Comparator Bank

This block watches the CPU instruction-fetch address and stops the core when execution reaches one of up to four addresses chosen by a debug host. Each slot holds an enable flag and a 16-bit code address. The host programs a slot by streaming a three-byte command into a byte-wide port, one byte per strobe. The slot is rewritten only when the last byte arrives, so a half-sent command never disturbs a comparator that is already armed.

On every cycle with a valid fetch address, the block compares that address against all enabled slots. Any equality sets a registered, sticky halt request and records which slots hit in a hit vector. Both stay set until the debug side pulses resume. The transport that carries the command bytes and the CPU core itself are outside the block.

Top module: `hw_brkpt_unit`

## Requirements
- R1: After reset, `halt_req` is 0, `hit_vec` is 0, all four slots are disabled and every slot address is 0, so a valid fetch of address 0x0000 does not halt.
- R2: A command is three bytes taken on strobes. In byte one, bits 4:3 pick the slot (0 to 3) and bit 2 is the enable (1 arms the slot, 0 disarms it). Bits 7:5 have no effect. Byte two is address bits 15:8 and byte three is address bits 7:0.
- R3: A slot changes only at the clock edge that takes the third byte. After one or two bytes, the slots still behave as before.
- R4: When bits 1:0 of byte one are not 00, the whole command is dropped and no slot changes. The next strobe starts a new command.
- R5: A valid fetch whose address equals an enabled slot's address makes `halt_req` 1 at the next clock edge.
- R6: While `cpu_addr_vld` is 0, no comparison takes place, and `halt_req` and `hit_vec` do not change except through resume.
- R7: A disabled slot never causes a hit, whatever its stored address.
- R8: `halt_req` stays 1 until a cycle with `resume` at 1 and no new match. After that cycle it is 0 and `hit_vec` is 0.
- R9: Bit i of `hit_vec` is set at the edge after slot i matches. Several slots can set their bits in the same cycle, and later hits OR into the vector until resume.
- R10: When resume and a match fall in the same cycle, the match wins. `halt_req` stays 1 and `hit_vec` holds only the new match.
- R11: When the third command byte and a valid fetch fall in the same cycle, the fetch is compared against the configuration from before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_byte | input | 8 | Command payload byte |
| cfg_strobe | input | 1 | Takes `cfg_byte` this cycle |
| cpu_addr | input | 16 | CPU code fetch address |
| cpu_addr_vld | input | 1 | Fetch address qualifier |
| resume | input | 1 | Clears the halt request and hit vector |
| halt_req | output | 1 | Sticky halt request to the core |
| hit_vec | output | 4 | Slots that matched since the last resume |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is resume and a new match. The bench drives `resume` during a cycle whose fetch address hits an armed slot, then expects the halt to survive and the hit vector to hold only that fresh slot. The second pair is a slot write and a comparison. The bench sends the final command byte while fetching the very address being programmed, then expects no hit on that cycle and a hit on the next fetch of the same address. A scoreboard model in the bench predicts the outcome of every such cycle from the requirements alone.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  localparam int CMD_BYTE_W = 8;
  localparam int SLOT_SEL_W = 2;
  localparam int SEL_LSB    = 3;
  localparam int ARM_BIT    = 2;
  localparam int RSVD_W     = 2;
  localparam int CODE_AW    = 2 * CMD_BYTE_W;

  typedef enum logic [1:0] {
    PH_HEAD = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } load_phase_e;

  typedef struct packed {
    logic                  arm;
    logic [SLOT_SEL_W-1:0] sel;
    logic [CODE_AW-1:0]    addr;
  } slot_cmd_t;

  function automatic logic head_rsvd_ok(input logic [CMD_BYTE_W-1:0] head);
    return head[RSVD_W-1:0] == '0;
  endfunction

  function automatic logic [SLOT_SEL_W-1:0] head_sel(input logic [CMD_BYTE_W-1:0] head);
    return head[SEL_LSB +: SLOT_SEL_W];
  endfunction

  function automatic logic head_arm(input logic [CMD_BYTE_W-1:0] head);
    return head[ARM_BIT];
  endfunction

  function automatic logic addr_hit(input logic armed,
                                    input logic [CODE_AW-1:0] slot_addr,
                                    input logic [CODE_AW-1:0] bus_addr,
                                    input logic bus_vld);
    return armed && bus_vld && (slot_addr == bus_addr);
  endfunction

endpackage

// File: rtl/bkpt_cfg_loader.sv
module bkpt_cfg_loader
  import bkpt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CMD_BYTE_W-1:0] byte_in,
  input  logic                  byte_stb,
  output logic                  cmd_commit,
  output logic                  cmd_reject,
  output slot_cmd_t             cmd
);

  load_phase_e           phase_q;
  logic [CMD_BYTE_W-1:0] head_q;
  logic [CMD_BYTE_W-1:0] high_q;
  logic                  last_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HEAD;
      head_q  <= '0;
      high_q  <= '0;
    end else if (byte_stb) begin
      unique case (phase_q)
        PH_HEAD: begin
          head_q  <= byte_in;
          phase_q <= PH_HIGH;
        end
        PH_HIGH: begin
          high_q  <= byte_in;
          phase_q <= PH_LOW;
        end
        default: phase_q <= PH_HEAD;
      endcase
    end
  end

  assign last_byte  = byte_stb && (phase_q == PH_LOW);
  assign cmd_commit = last_byte && head_rsvd_ok(head_q);
  assign cmd_reject = last_byte && !head_rsvd_ok(head_q);

  always_comb begin
    cmd.arm  = head_arm(head_q);
    cmd.sel  = head_sel(head_q);
    cmd.addr = {high_q, byte_in};
  end

endmodule

// File: rtl/bkpt_slot.sv
module bkpt_slot
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = CODE_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              wr_arm,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_vld,
  output logic              armed,
  output logic              hit
);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      addr_q <= '0;
    end else if (wr) begin
      armed  <= wr_arm;
      addr_q <= wr_addr;
    end
  end

  assign hit = addr_hit(armed, addr_q, bus_addr, bus_vld);

endmodule

// File: rtl/bkpt_halt_ctl.sv
module bkpt_halt_ctl #(
  parameter int NUM_SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] slot_hits,
  input  logic                 resume,
  output logic                 halt_req,
  output logic [NUM_SLOTS-1:0] hit_vec
);

  logic [NUM_SLOTS-1:0] kept;

  assign kept = resume ? '0 : hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_vec  <= '0;
      halt_req <= 1'b0;
    end else begin
      hit_vec  <= kept | slot_hits;
      halt_req <= (halt_req && !resume) || (|slot_hits);
    end
  end

endmodule

// File: rtl/hw_brkpt_unit.sv
module hw_brkpt_unit
  import bkpt_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CMD_BYTE_W-1:0] cfg_byte,
  input  logic                  cfg_strobe,
  input  logic [CODE_AW-1:0]    cpu_addr,
  input  logic                  cpu_addr_vld,
  input  logic                  resume,
  output logic                  halt_req,
  output logic [NUM_SLOTS-1:0]  hit_vec
);

  localparam int SEL_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic                 cfg_commit;
  logic                 cfg_reject;
  slot_cmd_t            cfg_cmd;
  logic [NUM_SLOTS-1:0] slot_en;
  logic [NUM_SLOTS-1:0] match_vec;

  bkpt_cfg_loader u_loader (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_in    (cfg_byte),
    .byte_stb   (cfg_strobe),
    .cmd_commit (cfg_commit),
    .cmd_reject (cfg_reject),
    .cmd        (cfg_cmd)
  );

  for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
    logic slot_wr;
    assign slot_wr = cfg_commit && (cfg_cmd.sel[SEL_W-1:0] == SEL_W'(gi));

    bkpt_slot #(.ADDR_W(CODE_AW)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (slot_wr),
      .wr_arm   (cfg_cmd.arm),
      .wr_addr  (cfg_cmd.addr),
      .bus_addr (cpu_addr),
      .bus_vld  (cpu_addr_vld),
      .armed    (slot_en[gi]),
      .hit      (match_vec[gi])
    );
  end

  bkpt_halt_ctl #(.NUM_SLOTS(NUM_SLOTS)) u_halt (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_hits (match_vec),
    .resume    (resume),
    .halt_req  (halt_req),
    .hit_vec   (hit_vec)
  );

endmodule

// File: rtl/hw_brkpt_unit_chk.sv
module hw_brkpt_unit_chk #(
  parameter int NUM_SLOTS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cpu_addr_vld,
  input logic                 resume,
  input logic                 halt_req,
  input logic [NUM_SLOTS-1:0] hit_vec,
  input logic [NUM_SLOTS-1:0] match_vec,
  input logic [NUM_SLOTS-1:0] slot_en,
  input logic                 cfg_commit,
  input logic                 cfg_reject
);

  // R5
  match_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|match_vec) |=> halt_req);

  // R9
  hit_tracks_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req == (hit_vec != '0));

  // R8
  resume_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resume && !(|match_vec)) |=> (!halt_req && hit_vec == '0));

  // R10
  resume_loses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resume && (|match_vec)) |=> (halt_req && hit_vec == $past(match_vec)));

  // R6
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_addr_vld && !resume) |=> $stable(hit_vec));

  // R3
  no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_commit |=> $stable(slot_en));

  // R4
  reject_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_commit && cfg_reject));

  // R7
  armed_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_vec & ~slot_en) == '0);

endmodule

bind hw_brkpt_unit hw_brkpt_unit_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_addr_vld (cpu_addr_vld),
  .resume       (resume),
  .halt_req     (halt_req),
  .hit_vec      (hit_vec),
  .match_vec    (match_vec),
  .slot_en      (slot_en),
  .cfg_commit   (cfg_commit),
  .cfg_reject   (cfg_reject)
);

// File: tb/hw_brkpt_unit_tb.sv
module hw_brkpt_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_byte = '0;
  logic        cfg_strobe = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_addr_vld = 1'b0;
  logic        resume = 1'b0;
  logic        halt_req;
  logic [3:0]  hit_vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hw_brkpt_unit u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_byte     (cfg_byte),
    .cfg_strobe   (cfg_strobe),
    .cpu_addr     (cpu_addr),
    .cpu_addr_vld (cpu_addr_vld),
    .resume       (resume),
    .halt_req     (halt_req),
    .hit_vec      (hit_vec)
  );

  typedef struct {
    logic       h;
    logic [3:0] v;
    string      tag;
  } exp_t;

  exp_t sb[$];

  // reference model state
  logic        m_en [4];
  logic [15:0] m_ad [4];
  int          m_ph = 0;
  logic [7:0]  m_head = '0;
  logic [7:0]  m_hi = '0;
  logic        m_halt = 1'b0;
  logic [3:0]  m_hit = '0;

  task automatic step(input logic sv, input logic [7:0] b, input logic [15:0] a,
                      input logic v, input logic r, input string tag);
    logic [3:0] mt;
    exp_t e;
    @(negedge clk);
    cfg_strobe = sv; cfg_byte = b; cpu_addr = a; cpu_addr_vld = v; resume = r;
    mt = '0;
    for (int i = 0; i < 4; i++) mt[i] = v && m_en[i] && (m_ad[i] == a);
    m_halt = (m_halt && !r) || (mt != 0);
    m_hit  = (r ? 4'b0 : m_hit) | mt;
    e.h = m_halt; e.v = m_hit; e.tag = tag;
    sb.push_back(e);
    if (sv) begin
      if (m_ph == 0) begin m_head = b; m_ph = 1; end
      else if (m_ph == 1) begin m_hi = b; m_ph = 2; end
      else begin
        m_ph = 0;
        if (m_head[1:0] == 2'b00) begin
          m_en[m_head[4:3]] = m_head[2];
          m_ad[m_head[4:3]] = {m_hi, b};
        end
      end
    end
  endtask

  task automatic payload(input logic [7:0] head, input logic [15:0] a, input string tag);
    step(1, head, 16'h0, 0, 0, tag);
    step(1, a[15:8], 16'h0, 0, 0, tag);
    step(1, a[7:0], 16'h0, 0, 0, tag);
  endtask

  task automatic fetch(input logic [15:0] a, input string tag);
    step(0, 8'h0, a, 1, 0, tag);
  endtask

  task automatic do_resume(input string tag);
    step(0, 8'h0, 16'h0, 0, 1, tag);
  endtask

  function automatic logic [7:0] hdr(input int slot, input logic en);
    return {3'b000, slot[1:0], en, 2'b00};
  endfunction

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (halt_req !== e.h || hit_vec !== e.v) begin
          errors++;
          $display("FAIL %s: halt=%b hit=%b expected halt=%b hit=%b",
                   e.tag, halt_req, hit_vec, e.h, e.v);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_en[i] = 1'b0; m_ad[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (halt_req !== 1'b0 || hit_vec !== 4'b0) begin
      errors++;
      $display("FAIL R1: halt=%b hit=%b expected halt=0 hit=0000", halt_req, hit_vec);
    end
    fetch(16'h0000, "R1");

    payload(hdr(0, 1), 16'h1234, "R2");
    fetch(16'h1235, "R5");
    step(0, 8'h0, 16'h1234, 0, 0, "R6");
    fetch(16'h1234, "R5");
    step(0, 8'h0, 16'h0000, 0, 0, "R8");
    do_resume("R8");

    payload(8'hE0 | hdr(1, 1), 16'hABCD, "R2");
    fetch(16'hABCD, "R2");
    do_resume("R8");

    payload(hdr(3, 1), 16'hABCD, "R9");
    fetch(16'hABCD, "R9");
    fetch(16'h1234, "R9");
    step(0, 8'h0, 16'h1234, 1, 1, "R10");
    do_resume("R8");

    payload(hdr(0, 0), 16'h1234, "R7");
    fetch(16'h1234, "R7");

    payload(hdr(2, 1) | 8'h01, 16'h4444, "R4");
    fetch(16'h4444, "R4");
    payload(hdr(1, 0) | 8'h02, 16'hABCD, "R4");
    fetch(16'hABCD, "R4");
    do_resume("R8");

    payload(hdr(0, 1), 16'h1234, "R3");
    step(1, hdr(0, 1), 16'h0, 0, 0, "R3");
    step(1, 8'h55, 16'h0, 0, 0, "R3");
    fetch(16'h1234, "R3");
    fetch(16'h5566, "R3");
    do_resume("R8");
    step(1, 8'h66, 16'h0, 0, 0, "R3");
    fetch(16'h5566, "R3");
    do_resume("R8");

    step(1, hdr(2, 1), 16'h0, 0, 0, "R11");
    step(1, 8'h77, 16'h0, 0, 0, "R11");
    step(1, 8'h77, 16'h7777, 1, 0, "R11");
    fetch(16'h7777, "R11");
    do_resume("R8");

    step(0, 8'h0, 16'h0, 0, 0, "R6");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule